// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller with Spurious Reporting

This block collects interrupt requests from eight lines and presents one interrupt request output to a single CPU. Each line passes through a two-flop synchronizer. A request is recorded only when the synchronized line goes from low to high. Any recorded request that is neither masked nor blocked by a line in service drives `irq_out` high.

When the CPU answers with a one-cycle acknowledge strobe, the controller chooses a line from the synchronized levels present at that moment, not from the recorded edges alone. The chosen line is the highest-priority line that is unmasked, not blocked, has a recorded edge and is still high. Line 0 has the highest priority and line 7 the lowest. The chosen line moves into service. If no line qualifies, the controller returns ID 7 and raises a spurious flag. This happens when a line drops after raising `irq_out`, when the qualifying lines are masked, or when no request was made at all.

An end-of-interrupt pulse takes the highest-priority line out of service. A line in service keeps lines of equal and lower priority from raising `irq_out` and from being granted.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A line records a request only when its synchronized level rises from low to high. `irq_out` rises three clock edges after the input rises. A line that stays high records nothing more until it falls and rises again.
- R2: `irq_out` is high exactly when some recorded request is unmasked and not blocked by the in-service state.
- R3: On `ack_strobe`, the granted line is the lowest-numbered line that is unmasked, not blocked, has a recorded request and is high in the synchronized sample. The grant clears that line's recorded request and sets its in-service bit. `vec_id` returns the line number as a 3-bit binary value, and `vec_spurious` is 0.
- R4: If no line qualifies at `ack_strobe`, `vec_id` is 7 and `vec_spurious` is 1, and no in-service bit is set. The acknowledge also discards the recorded requests of every unmasked, unblocked line that is low in the sample.
- R5: A mask bit of 1 masks the line with the same index. A masked line neither raises `irq_out` nor is granted, even when its request is already recorded. A pulse on `mask_wr` loads `mask_wdata`.
- R6: An in-service line blocks itself and every higher-numbered line. An `eoi` pulse clears the lowest-numbered in-service bit.
- R7: `vec_valid` is high for exactly the one cycle after the clock edge that samples `ack_strobe`. `vec_id` and `vec_spurious` are meaningful in that cycle.
- R8: While `rst` is high at a clock edge, the controller clears the recorded requests, the in-service bits, the mask (all lines unmasked), the synchronizers and `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Asynchronous request lines |
| mask_wr | input | 1 | Mask register load strobe |
| mask_wdata | input | 8 | New mask value, 1 = masked |
| ack_strobe | input | 1 | CPU acknowledge, one cycle |
| eoi | input | 1 | End of interrupt, one cycle |
| irq_out | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Result of the acknowledge is valid |
| vec_id | output | 3 | Granted line, or 7 |
| vec_spurious | output | 1 | Result is spurious |

## Verification
The hardest case to reach is a spurious acknowledge while `irq_out` is still high. It needs a request that was recorded, raised `irq_out`, and whose line then fell before the sample. The stimulus raises a line, waits three edges for `irq_out`, drops the line, and then waits two more edges so that the synchronized level is low before the acknowledge. A later rise of line 7 shows that the spurious acknowledge set no in-service bit. A second scenario stacks grants under the in-service rule: a blocked request stays silent until each of two `eoi` pulses has cleared an in-service bit.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int N = 8,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   irq_lines,
  input  logic           mask_wr,
  input  logic [N-1:0]   mask_wdata,
  input  logic           ack_strobe,
  input  logic           eoi,
  output logic           irq_out,
  output logic           vec_valid,
  output logic [IDW-1:0] vec_id,
  output logic           vec_spurious
);
  localparam logic [IDW-1:0] SPUR_ID = IDW'(N - 1);

  logic [N-1:0] sync1, sync2, prev, pend, isr, mask_q;
  logic [N-1:0] allow, cand, gnt, eoi_clr, drop;
  logic [IDW-1:0] gnt_id;

  wire [N-1:0] rise = sync2 & ~prev;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      allow[i] = ~(seen | isr[i]);
      seen = seen | isr[i];
    end
  end

  assign cand = pend & ~mask_q & allow & sync2;
  assign drop = ack_strobe ? (pend & ~mask_q & allow & ~sync2) : '0;
  assign irq_out = |(pend & ~mask_q & allow);

  always_comb begin
    gnt = '0;
    gnt_id = SPUR_ID;
    eoi_clr = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        gnt = '0;
        gnt[i] = ack_strobe;
        gnt_id = IDW'(i);
      end
      if (isr[i]) begin
        eoi_clr = '0;
        eoi_clr[i] = eoi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      prev <= '0;
      pend <= '0;
      isr <= '0;
      mask_q <= '0;
      vec_valid <= 1'b0;
      vec_id <= '0;
      vec_spurious <= 1'b0;
    end else begin
      sync1 <= irq_lines;
      sync2 <= sync1;
      prev <= sync2;
      pend <= (pend & ~gnt & ~drop) | rise;
      isr <= (isr & ~eoi_clr) | gnt;
      if (mask_wr) mask_q <= mask_wdata;
      vec_valid <= ack_strobe;
      if (ack_strobe) begin
        vec_id <= gnt_id;
        vec_spurious <= ~|cand;
      end
    end
  end

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_strobe |=> vec_valid); // R7
  AST_VALID_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack_strobe)); // R7
  AST_SPUR_ID: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_spurious) |-> vec_id == SPUR_ID); // R4
  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack_strobe && !(|cand) && !eoi) |=> $stable(isr)); // R4
  AST_GRANT_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_spurious) |-> isr[vec_id]); // R3
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> |(pend & ~mask_q)); // R5
  AST_ISR_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (isr == '0 && !vec_valid && !irq_out)); // R8
endmodule

// File: tb/edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_lines = '0;
  logic mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic ack_strobe = 1'b0;
  logic eoi = 1'b0;
  logic irq_out, vec_valid, vec_spurious;
  logic [2:0] vec_id;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .ack_strobe(ack_strobe), .eoi(eoi),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_id(vec_id),
    .vec_spurious(vec_spurious)
  );

  // {mask, raise, drop, exp_irq, exp_id, exp_spurious}
  localparam logic [28:0] VEC [9] = '{
    {8'h00, 8'h01, 8'h00, 1'b1, 3'd0, 1'b0},
    {8'h00, 8'h28, 8'h00, 1'b1, 3'd3, 1'b0},
    {8'h00, 8'h28, 8'h08, 1'b1, 3'd5, 1'b0},
    {8'h00, 8'h10, 8'h10, 1'b1, 3'd7, 1'b1},
    {8'h10, 8'h10, 8'h00, 1'b0, 3'd7, 1'b1},
    {8'h00, 8'h80, 8'h00, 1'b1, 3'd7, 1'b0},
    {8'h01, 8'h03, 8'h00, 1'b1, 3'd1, 1'b0},
    {8'hFF, 8'hFF, 8'h00, 1'b0, 3'd7, 1'b1},
    {8'h00, 8'h00, 8'h00, 1'b0, 3'd7, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_lines = '0; ack_strobe = 1'b0; eoi = 1'b0; mask_wr = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_wr = 1'b1; mask_wdata = m;
    tick(1);
    mask_wr = 1'b0;
  endtask

  task automatic do_ack(input string req, input logic [2:0] id, input logic spur);
    ack_strobe = 1'b1;
    tick(1);
    ack_strobe = 1'b0;
    check({req, " valid"}, 8'(vec_valid), 8'd1);
    check({req, " id"}, 8'(vec_id), 8'(id));
    check({req, " spurious"}, 8'(vec_spurious), 8'(spur));
    tick(1);
    check("R7 valid one cycle", 8'(vec_valid), 8'd0);
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1;
    tick(1);
    eoi = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(1);
    check("R8 reset irq_out", 8'(irq_out), 8'd0);
    check("R8 reset vec_valid", 8'(vec_valid), 8'd0);

    for (int v = 0; v < 9; v++) begin
      do_reset();
      write_mask(VEC[v][28:21]);
      irq_lines = VEC[v][20:13];
      tick(3);
      irq_lines = irq_lines & ~VEC[v][12:5];
      tick(2);
      check("R2/R5 vector irq_out", 8'(irq_out), 8'(VEC[v][4]));
      do_ack("R3/R4 vector", VEC[v][3:1], VEC[v][0]);
    end

    // R1: held-high line does not re-request; fall and rise does
    do_reset();
    irq_lines = 8'h04;
    tick(2);
    check("R1 not yet after two edges", 8'(irq_out), 8'd0);
    tick(1);
    check("R1 irq_out after three edges", 8'(irq_out), 8'd1);
    do_ack("R3 grant line 2", 3'd2, 1'b0);
    pulse_eoi();
    tick(4);
    check("R1 held high no repeat", 8'(irq_out), 8'd0);
    irq_lines = 8'h00;
    tick(3);
    irq_lines = 8'h04;
    tick(3);
    check("R1 new rise requests", 8'(irq_out), 8'd1);

    // R6: in-service blocking and eoi order
    do_reset();
    irq_lines = 8'h10;
    tick(3);
    do_ack("R6 grant line 4", 3'd4, 1'b0);
    irq_lines = 8'h50;
    tick(3);
    check("R6 line 6 blocked by 4", 8'(irq_out), 8'd0);
    irq_lines = 8'h52;
    tick(3);
    check("R6 line 1 passes", 8'(irq_out), 8'd1);
    do_ack("R6 grant line 1", 3'd1, 1'b0);
    pulse_eoi();
    check("R6 eoi clears 1, 4 still blocks", 8'(irq_out), 8'd0);
    pulse_eoi();
    check("R6 eoi clears 4", 8'(irq_out), 8'd1);
    do_ack("R6 grant line 6", 3'd6, 1'b0);

    // R4: spurious discards stale edge, sets no in-service bit
    do_reset();
    irq_lines = 8'h10;
    tick(3);
    irq_lines = 8'h00;
    tick(2);
    check("R4 irq_out still high", 8'(irq_out), 8'd1);
    do_ack("R4 spurious", 3'd7, 1'b1);
    check("R4 stale edge discarded", 8'(irq_out), 8'd0);
    irq_lines = 8'h80;
    tick(3);
    check("R4 no in-service after spurious", 8'(irq_out), 8'd1);
    do_ack("R4 genuine line 7", 3'd7, 1'b0);

    // R5: mask applied after edge recorded
    do_reset();
    irq_lines = 8'h01;
    tick(3);
    write_mask(8'h01);
    check("R5 masked after record", 8'(irq_out), 8'd0);
    do_ack("R5 masked ack", 3'd7, 1'b1);

    // R8: reset clears in-service and mask
    do_reset();
    write_mask(8'hFF);
    do_reset();
    irq_lines = 8'h08;
    tick(3);
    check("R8 mask cleared by reset", 8'(irq_out), 8'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule